// File: doc/BRIEF.md
# Protected Dual Store-Queue Unit

The unit holds two small store queues of eight 32-bit longwords each. The processor fills a queue one longword at a time. A flush command then sends the whole queue to external memory as a burst of eight beats, one beat per cycle. A privileged readback port returns any single longword from either queue.

Every queue write and every flush request goes through an access judge first. The judge looks at four things: whether address translation is enabled, a queue-mode bit that can limit access to privileged code, the current processor mode, and a translation result. The translation result comes from an outside lookup as four flags: hit, read permitted, write permitted and page dirty.

A rejected access changes nothing in the queues. Instead it raises a one-hot exception vector for one cycle, together with a reject strobe. A bus fault during a burst stops the burst at once. The unit expects at most one of write, flush request and readback in any cycle. If more than one arrives, the exception vector reports the write first, then the flush, then the readback.

Top module: `sq_unit`

## Requirements
- R1: After reset, `busValid`, `flushDone`, `flushAbort`, `rdAck` and `excStrobe` are 0, `excVec` is 0, and every queue longword reads back as 0.
- R2: An accepted write (`wrValid`) stores `wrData` at queue `wrQueue`, longword `wrIdx`, at the clock edge. It reports no exception.
- R3: When `privOnly`=1 and `userMode`=1, a write or a flush request is rejected with the address-error bit, `excVec`=4'b0001. The translation flags make no difference. When `privOnly`=0, user-mode access is allowed.
- R4: When `mmuOn`=0, the translation flags are ignored for writes and flushes.
- R5: When `mmuOn`=1, a write is judged as a write-type access. A miss gives 4'b0010, a clear write permission gives 4'b0100, and a clean page gives 4'b1000, checked in that order.
- R6: When `mmuOn`=1, a flush is judged as a read-type access. A miss gives 4'b0010 and a clear read permission gives 4'b0100. The write permission and dirty flags do not matter. A rejected flush sends no beats.
- R7: A rejected write leaves the addressed longword unchanged.
- R8: An accepted flush request drives `busValid` in each of the eight following cycles. Each beat carries the stored longword, with `busIdx` counting 0 to 7 and `busQueue` set to the chosen queue. In the cycle after the last beat, `flushDone` pulses for one cycle and `busValid` is 0.
- R9: If `busFault` is 1 during a beat, that beat is the last one. `flushAbort` pulses in the next cycle, `flushDone` does not pulse, and the queue contents are kept.
- R10: In the readback address `rdAddr`, bit 5 selects the queue, bits 4:2 select the longword, and bits 1:0 must be 0. `rdSize` must equal 2'b10, which means longword. A legal privileged readback returns the longword, with `rdAck` high, in the next cycle.
- R11: A readback is rejected if it comes from user mode, if `rdSize` is not 2'b10, or if bits 1:0 of the address are not 0. A rejected readback returns `rdData`=0 with `excVec`=4'b0001 and does not depend on `privOnly` or `mmuOn`.
- R12: `excVec` is one-hot whenever `excStrobe` is 1 and 0 otherwise. Both appear in the cycle after the rejected request and last for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mmuOn | input | 1 | Address translation enabled |
| privOnly | input | 1 | Queue-mode bit: 1 limits queue access to privileged mode |
| userMode | input | 1 | Current processor mode is user |
| tlbHit | input | 1 | Translation lookup hit |
| tlbReadOk | input | 1 | Page allows reads in the current mode |
| tlbWriteOk | input | 1 | Page allows writes in the current mode |
| tlbDirty | input | 1 | Page already marked written |
| wrValid | input | 1 | Queue write request |
| wrQueue | input | 1 | Target queue of the write |
| wrIdx | input | 3 | Target longword of the write |
| wrData | input | 32 | Write data |
| flushReq | input | 1 | Flush request |
| flushQueue | input | 1 | Queue to flush |
| busFault | input | 1 | Memory-side fault during a beat |
| busValid | output | 1 | Burst beat valid |
| busQueue | output | 1 | Queue being flushed |
| busIdx | output | 3 | Longword index of the beat |
| busData | output | 32 | Beat data |
| flushDone | output | 1 | Flush completed, one-cycle pulse |
| flushAbort | output | 1 | Flush aborted, one-cycle pulse |
| rdValid | input | 1 | Readback request |
| rdAddr | input | 6 | Readback offset within the 64-byte window |
| rdSize | input | 2 | Access size, 2'b10 for longword |
| rdAck | output | 1 | Readback response valid |
| rdData | output | 32 | Readback data, 0 when rejected |
| excVec | output | 4 | One-hot exception: bit0 address error, bit1 miss, bit2 protection, bit3 first write to a clean page |
| excStrobe | output | 1 | Access rejected |

## Verification
The bench targets the points where the exception order matters:
- A user-mode write with `privOnly` set while the translation flags also fail. A wrong order would report a miss instead of an address error.
- A flush with the dirty flag clear. A design that judged the flush as a write would raise a clean-page exception here.
- A faulting beat placed on the first beat, a middle beat and the last beat. A design that kept issuing beats or pulsed both done and abort would show it.
- Rejected writes and misaligned or wrongly sized readbacks. These are followed by legal readbacks, which expose any overwritten queue data and any stale data returned by an error response.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef logic [3:0] exc_t;

  localparam int EXC_ADDR   = 0;
  localparam int EXC_MISS   = 1;
  localparam int EXC_PROT   = 2;
  localparam int EXC_INITWR = 3;

  typedef enum logic {ACC_READ = 1'b0, ACC_WRITE = 1'b1} acc_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic rdOk;
    logic bufQ;
  } sq_strobe_t;

  function automatic exc_t judgeAccess(acc_e kind, logic mmu, logic privOnly,
                                       logic user, logic hit, logic rdOk,
                                       logic wrOk, logic dirty);
    exc_t e;
    e = '0;
    if (privOnly && user) begin
      e[EXC_ADDR] = 1'b1;
    end else if (mmu) begin
      if (!hit) e[EXC_MISS] = 1'b1;
      else if ((kind == ACC_READ) ? !rdOk : !wrOk) e[EXC_PROT] = 1'b1;
      else if (kind == ACC_WRITE && !dirty) e[EXC_INITWR] = 1'b1;
    end
    return e;
  endfunction

endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int LW_PER_Q = 8,
  localparam int IDX_W = $clog2(LW_PER_Q)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mmuOn,
  input  logic             privOnly,
  input  logic             userMode,
  input  logic             tlbHit,
  input  logic             tlbReadOk,
  input  logic             tlbWriteOk,
  input  logic             tlbDirty,
  input  logic             wrValid,
  input  logic             flushReq,
  input  logic             flushQueue,
  input  logic             busFault,
  input  logic             rdValid,
  input  logic [1:0]       rdLow,
  input  logic [1:0]       rdSize,
  output sq_strobe_t       stb,
  output logic [IDX_W-1:0] bufIdx,
  output logic             busValid,
  output logic             flushDone,
  output logic             flushAbort,
  output logic             rdAck,
  output exc_t             excVec,
  output logic             excStrobe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LW_PER_Q - 1);
  localparam logic [1:0]       SIZE_LW  = 2'b10;

  exc_t wrExc, flExc, rdExc, excNext;
  logic busy, bufQ, flStart;

  always_comb begin
    wrExc = judgeAccess(ACC_WRITE, mmuOn, privOnly, userMode,
                        tlbHit, tlbReadOk, tlbWriteOk, tlbDirty);
    flExc = judgeAccess(ACC_READ, mmuOn, privOnly, userMode,
                        tlbHit, tlbReadOk, tlbWriteOk, tlbDirty);
    rdExc = '0;
    rdExc[EXC_ADDR] = userMode || (rdSize != SIZE_LW) || (rdLow != 2'b00);
    flStart = flushReq && !busy;
    if (wrValid)      excNext = wrExc;
    else if (flStart) excNext = flExc;
    else if (rdValid) excNext = rdExc;
    else              excNext = '0;
  end

  assign stb.wrEn = wrValid && (wrExc == '0);
  assign stb.rdEn = rdValid;
  assign stb.rdOk = (rdExc == '0);
  assign stb.bufQ = bufQ;
  assign busValid = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      bufQ       <= 1'b0;
      bufIdx     <= '0;
      flushDone  <= 1'b0;
      flushAbort <= 1'b0;
    end else begin
      flushDone  <= 1'b0;
      flushAbort <= 1'b0;
      if (busy) begin
        if (busFault) begin
          busy       <= 1'b0;
          flushAbort <= 1'b1;
        end else if (bufIdx == LAST_IDX) begin
          busy      <= 1'b0;
          flushDone <= 1'b1;
        end else begin
          bufIdx <= bufIdx + 1'b1;
        end
      end else if (flStart && flExc == '0) begin
        busy   <= 1'b1;
        bufIdx <= '0;
        bufQ   <= flushQueue;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAck     <= 1'b0;
      excVec    <= '0;
      excStrobe <= 1'b0;
    end else begin
      rdAck     <= rdValid;
      excVec    <= excNext;
      excStrobe <= (excNext != '0);
    end
  end

endmodule

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LW_PER_Q = 8,
  localparam int IDX_W = $clog2(LW_PER_Q)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sq_strobe_t        stb,
  input  logic              wrQueue,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  bufIdx,
  input  logic [IDX_W:0]    rdSel,
  output logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] rdData
);

  localparam int NUM_Q = 2;

  logic [DATA_W-1:0] store [NUM_Q][LW_PER_Q];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_Q; q++)
        for (int i = 0; i < LW_PER_Q; i++)
          store[q][i] <= '0;
    end else if (stb.wrEn) begin
      store[wrQueue][wrIdx] <= wrData;
    end
  end

  assign busData = store[stb.bufQ][bufIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdEn) begin
      rdData <= stb.rdOk ? store[rdSel[IDX_W]][rdSel[IDX_W-1:0]] : '0;
    end
  end

endmodule

// File: rtl/sq_unit.sv
module sq_unit
  import sq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LW_PER_Q = 8,
  localparam int IDX_W = $clog2(LW_PER_Q),
  localparam int RD_W  = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mmuOn,
  input  logic              privOnly,
  input  logic              userMode,
  input  logic              tlbHit,
  input  logic              tlbReadOk,
  input  logic              tlbWriteOk,
  input  logic              tlbDirty,
  input  logic              wrValid,
  input  logic              wrQueue,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flushReq,
  input  logic              flushQueue,
  input  logic              busFault,
  output logic              busValid,
  output logic              busQueue,
  output logic [IDX_W-1:0]  busIdx,
  output logic [DATA_W-1:0] busData,
  output logic              flushDone,
  output logic              flushAbort,
  input  logic              rdValid,
  input  logic [RD_W-1:0]   rdAddr,
  input  logic [1:0]        rdSize,
  output logic              rdAck,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        excVec,
  output logic              excStrobe
);

  sq_strobe_t stb;

  sq_ctrl #(.LW_PER_Q(LW_PER_Q)) u_ctrl (
    .clk(clk), .rstN(rstN), .mmuOn(mmuOn), .privOnly(privOnly),
    .userMode(userMode), .tlbHit(tlbHit), .tlbReadOk(tlbReadOk),
    .tlbWriteOk(tlbWriteOk), .tlbDirty(tlbDirty), .wrValid(wrValid),
    .flushReq(flushReq), .flushQueue(flushQueue), .busFault(busFault),
    .rdValid(rdValid), .rdLow(rdAddr[1:0]), .rdSize(rdSize), .stb(stb),
    .bufIdx(busIdx), .busValid(busValid), .flushDone(flushDone),
    .flushAbort(flushAbort), .rdAck(rdAck), .excVec(excVec),
    .excStrobe(excStrobe)
  );

  sq_data #(.DATA_W(DATA_W), .LW_PER_Q(LW_PER_Q)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrQueue(wrQueue), .wrIdx(wrIdx),
    .wrData(wrData), .bufIdx(busIdx), .rdSel(rdAddr[RD_W-1:2]),
    .busData(busData), .rdData(rdData)
  );

  assign busQueue = stb.bufQ;

endmodule

// File: rtl/sq_unit_chk.sv
module sq_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int LW_PER_Q = 8,
  localparam int IDX_W = $clog2(LW_PER_Q)
) (
  input logic              clk,
  input logic              rstN,
  input logic              privOnly,
  input logic              userMode,
  input logic              flushReq,
  input logic              busFault,
  input logic              busValid,
  input logic [IDX_W-1:0]  busIdx,
  input logic              flushDone,
  input logic              flushAbort,
  input logic              rdAck,
  input logic [DATA_W-1:0] rdData,
  input logic [3:0]        excVec,
  input logic              excStrobe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LW_PER_Q - 1);

  // R12
  exc_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    excStrobe |-> $onehot(excVec));

  // R12
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !excStrobe |-> (excVec == 4'b0000));

  // R8
  beat_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busFault && busIdx != LAST_IDX) |=>
      (busValid && busIdx == $past(busIdx) + 1'b1));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busFault && busIdx == LAST_IDX) |=> (flushDone && !busValid));

  // R9
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busFault) |=> (flushAbort && !flushDone && !busValid));

  // R3
  user_flush_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !busValid && privOnly && userMode) |=> !busValid);

  // R11
  rd_err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAck && excVec[0]) |-> (rdData == '0));

endmodule

bind sq_unit sq_unit_chk #(.DATA_W(DATA_W), .LW_PER_Q(LW_PER_Q)) u_chk (
  .clk(clk), .rstN(rstN), .privOnly(privOnly), .userMode(userMode),
  .flushReq(flushReq), .busFault(busFault), .busValid(busValid),
  .busIdx(busIdx), .flushDone(flushDone), .flushAbort(flushAbort),
  .rdAck(rdAck), .rdData(rdData), .excVec(excVec), .excStrobe(excStrobe)
);

// File: tb/sq_unit_bench.sv
module sq_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mmuOn = 0, privOnly = 0, userMode = 0;
  logic        tlbHit = 1, tlbReadOk = 1, tlbWriteOk = 1, tlbDirty = 1;
  logic        wrValid = 0, wrQueue = 0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        flushReq = 0, flushQueue = 0, busFault = 0;
  logic        busValid, busQueue, flushDone, flushAbort;
  logic [2:0]  busIdx;
  logic [31:0] busData;
  logic        rdValid = 0;
  logic [5:0]  rdAddr = '0;
  logic [1:0]  rdSize = 2'b10;
  logic        rdAck, excStrobe;
  logic [31:0] rdData;
  logic [3:0]  excVec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] model [2][8];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sq_unit u_sq_unit (
    .clk(clk), .rstN(rstN), .mmuOn(mmuOn), .privOnly(privOnly),
    .userMode(userMode), .tlbHit(tlbHit), .tlbReadOk(tlbReadOk),
    .tlbWriteOk(tlbWriteOk), .tlbDirty(tlbDirty), .wrValid(wrValid),
    .wrQueue(wrQueue), .wrIdx(wrIdx), .wrData(wrData), .flushReq(flushReq),
    .flushQueue(flushQueue), .busFault(busFault), .busValid(busValid),
    .busQueue(busQueue), .busIdx(busIdx), .busData(busData),
    .flushDone(flushDone), .flushAbort(flushAbort), .rdValid(rdValid),
    .rdAddr(rdAddr), .rdSize(rdSize), .rdAck(rdAck), .rdData(rdData),
    .excVec(excVec), .excStrobe(excStrobe)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expWrite(logic m, logic p, logic u, logic h,
                                          logic w, logic d);
    if (p && u) return 4'b0001;
    if (m && !h) return 4'b0010;
    if (m && !w) return 4'b0100;
    if (m && !d) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic [3:0] expFlush(logic m, logic p, logic u, logic h,
                                          logic r);
    if (p && u) return 4'b0001;
    if (m && !h) return 4'b0010;
    if (m && !r) return 4'b0100;
    return 4'b0000;
  endfunction

  task automatic setMode(logic m, logic p, logic u, logic h, logic r,
                         logic w, logic d);
    mmuOn = m; privOnly = p; userMode = u;
    tlbHit = h; tlbReadOk = r; tlbWriteOk = w; tlbDirty = d;
  endtask

  task automatic doWrite(logic q, logic [2:0] idx, logic [31:0] data, string req);
    logic [3:0] e;
    e = expWrite(mmuOn, privOnly, userMode, tlbHit, tlbWriteOk, tlbDirty);
    @(negedge clk);
    wrValid = 1; wrQueue = q; wrIdx = idx; wrData = data;
    @(posedge clk); #1;
    wrValid = 0;
    check(excVec == e && excStrobe == (e != 0), req, {excStrobe, excVec}, {(e != 0), e});
    if (e == 0) model[q][idx] = data;
  endtask

  task automatic doRead(logic q, logic [2:0] idx, logic u, logic [1:0] sz,
                        logic [1:0] low, string req);
    logic bad;
    logic [31:0] expD;
    bad = u || sz != 2'b10 || low != 2'b00;
    expD = bad ? 32'h0 : model[q][idx];
    @(negedge clk);
    rdValid = 1; rdAddr = {q, idx, low}; rdSize = sz; userMode = u;
    @(posedge clk); #1;
    rdValid = 0; rdSize = 2'b10;
    check(rdAck && rdData == expD && excVec == {3'b000, bad} && excStrobe == bad,
          req, {rdAck, excVec, rdData}, {1'b1, 3'b000, bad, expD});
  endtask

  task automatic doFlush(logic q, int faultAt, string req);
    logic [3:0] e;
    e = expFlush(mmuOn, privOnly, userMode, tlbHit, tlbReadOk);
    @(negedge clk);
    flushReq = 1; flushQueue = q;
    @(posedge clk); #1;
    flushReq = 0;
    check(excVec == e && excStrobe == (e != 0), req, {excStrobe, excVec}, {(e != 0), e});
    if (e != 0) begin
      check(!busValid, req, busValid, 0);
      @(posedge clk); #1;
      check(!busValid && !flushDone && !flushAbort, req,
            {busValid, flushDone, flushAbort}, 0);
      return;
    end
    for (int k = 0; k < 8; k++) begin
      check(busValid && busQueue == q && busIdx == 3'(k) && busData == model[q][k],
            "R8 beat", {busValid, busQueue, busIdx, busData},
            {1'b1, q, 3'(k), model[q][k]});
      if (k == faultAt) begin
        @(negedge clk); busFault = 1;
        @(posedge clk); #1; busFault = 0;
        check(flushAbort && !flushDone && !busValid, "R9 abort",
              {flushAbort, flushDone, busValid}, 3'b100);
        @(posedge clk); #1;
        check(!flushAbort && !busValid, "R9 quiet", {flushAbort, busValid}, 0);
        return;
      end
      @(posedge clk); #1;
    end
    check(flushDone && !flushAbort && !busValid, "R8 done",
          {flushDone, flushAbort, busValid}, 3'b100);
    @(posedge clk); #1;
    check(!flushDone, "R8 done pulse", flushDone, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] old;
    void'($urandom(32'd4711));
    for (int q = 0; q < 2; q++)
      for (int i = 0; i < 8; i++) model[q][i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    check(!busValid && !flushDone && !flushAbort && !rdAck && !excStrobe && excVec == 0,
          "R1 reset outputs", {busValid, flushDone, flushAbort, rdAck, excStrobe, excVec}, 0);
    doRead(1, 7, 0, 2'b10, 2'b00, "R1 reset contents");

    setMode(0, 0, 0, 1, 1, 1, 1);
    doWrite(0, 3, 32'hDEADBEEF, "R2 write");
    doRead(0, 3, 0, 2'b10, 2'b00, "R2 R10 readback");
    setMode(0, 0, 1, 0, 0, 0, 0);
    doWrite(1, 5, 32'h12345678, "R3 R4 user allowed mmu off");
    doRead(1, 5, 0, 2'b10, 2'b00, "R4 readback");
    setMode(1, 1, 1, 0, 0, 0, 0);
    doWrite(1, 5, 32'hBAD0BAD0, "R3 addr error over miss");
    doRead(1, 5, 0, 2'b10, 2'b00, "R7 kept after reject");
    setMode(0, 1, 1, 1, 1, 1, 1);
    doWrite(0, 3, 32'h0, "R3 mmu off user blocked");
    doRead(0, 3, 0, 2'b10, 2'b00, "R7 kept");
    setMode(1, 0, 0, 0, 1, 1, 1); doWrite(0, 0, 32'h1, "R5 miss");
    setMode(1, 0, 0, 1, 1, 0, 0); doWrite(0, 0, 32'h2, "R5 prot");
    setMode(1, 0, 0, 1, 1, 1, 0); doWrite(0, 0, 32'h3, "R5 initwr");
    doRead(0, 0, 0, 2'b10, 2'b00, "R7 after mmu rejects");
    setMode(1, 1, 0, 1, 1, 1, 1); doWrite(0, 1, 32'hA5A5A5A5, "R5 priv ok");
    doRead(0, 0, 1, 2'b10, 2'b00, "R11 user read");
    doRead(0, 1, 0, 2'b01, 2'b00, "R11 size");
    doRead(0, 1, 0, 2'b10, 2'b10, "R11 align");
    setMode(1, 0, 0, 0, 0, 0, 0);
    doRead(0, 1, 0, 2'b10, 2'b00, "R11 R10 mmu ignored");

    for (int i = 0; i < 8; i++) begin
      setMode(0, 0, 0, 1, 1, 1, 1);
      doWrite(1, 3'(i), 32'h100 + 32'(i), "R2 fill");
    end
    setMode(1, 0, 0, 1, 1, 0, 0);
    doFlush(1, 8, "R6 flush ignores dirty");
    setMode(1, 0, 0, 1, 0, 1, 1); doFlush(1, 8, "R6 flush prot");
    setMode(1, 0, 0, 0, 1, 1, 1); doFlush(1, 8, "R6 flush miss");
    setMode(0, 1, 1, 1, 1, 1, 1); doFlush(1, 8, "R3 flush user blocked");
    setMode(0, 0, 0, 1, 1, 1, 1);
    doFlush(1, 0, "R9 fault first");
    doFlush(1, 4, "R9 fault middle");
    doFlush(1, 7, "R9 fault last");
    old = model[1][7];
    doRead(1, 7, 0, 2'b10, 2'b00, "R9 contents kept");
    check(old == model[1][7], "R9 model", old, model[1][7]);

    for (int it = 0; it < 150; it++) begin
      int op;
      op = int'($urandom % 5);
      setMode(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) != 0,
              ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0);
      case (op)
        0, 1: doWrite(1'($urandom), 3'($urandom), $urandom, "R2 R5 random write");
        2, 3: doRead(1'($urandom), 3'($urandom), ($urandom % 4) == 0,
                     ($urandom % 4) == 0 ? 2'($urandom) : 2'b10,
                     ($urandom % 4) == 0 ? 2'($urandom) : 2'b00, "R10 R11 random read");
        default: doFlush(1'($urandom), ($urandom % 3) == 0 ? int'($urandom % 8) : 8,
                         "R6 R8 random flush");
      endcase
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule